// File: doc/BRIEF.md
# Dead-time PWM gate generator

This block produces the two gate-enable signals of a synchronous step-down power stage from a digital duty command. A free-running counter serves as the sawtooth ramp, and it wraps every `PERIOD` clock cycles. At each wrap the block samples the duty command, limits it to 90 % of the period, and holds it for the whole period. The high-side request is active while the ramp is below the held level. The low-side request is active for the rest of the period.

Each gate has its own turn-on delay, so a gate switches on only after its request has been continuously present for `DT` cycles. The other gate has already been dropped during that time, which gives a non-overlap gap on every transition. Deasserting the enable input, or raising the fault-off request, drives both gates low on the next clock. The ramp keeps running while the gates are off. A one-cycle strobe marks the first cycle of every period.

With the default 100 MHz clock, `PERIOD = 333` gives about 300 kHz, and `DT = 2` gives about 20 ns of dead time.

Top module: `sync_buck_pwm`

## Requirements
- R1: While the reset input is high, both gate outputs and the period strobe are low.
- R2: The effective duty is the command limited to MAX_ON = floor(PERIOD*90/100), which is 299 with the defaults. Any command above MAX_ON produces the same waveform as MAX_ON.
- R3: The two gates are never high in the same cycle. Every transition between them leaves both gates low for exactly DT cycles.
- R4: This requirement covers a period with effective duty d > 0 while the block is enabled, numbering cycles from 0 at the strobe cycle. The high gate is high exactly in cycles DT+1 to d. The low gate is high in cycle 0 and in cycles d+DT+1 to PERIOD-1.
- R5: A duty of zero keeps the high gate low, and the low gate stays high through the whole period.
- R6: A command change in the middle of a period has no effect on that period. It takes effect in the period that starts after the next strobe.
- R7: The period strobe is high for one cycle, once every PERIOD cycles, including while the gates are disabled.
- R8: From the cycle after the enable input goes low or the fault-off input goes high, both gates are low. They remain low for as long as that condition holds.
- R9: When the block is re-enabled inside the low-side part of the period, the low gate stays low for DT+1 cycles and rises in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low forces both gates off |
| duty_cmd | input | CW (9) | Requested high-side on-level in ramp counts |
| fault_off | input | 1 | High forces both gates off |
| hi_gate | output | 1 | High-side gate enable (registered) |
| lo_gate | output | 1 | Low-side gate enable (registered) |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
The ramp and the held duty are registered once, and each gate adds one more register stage. The strobe is high in the same cycle in which the ramp reads zero. A gate therefore reflects the ramp value of the previous cycle, which is why the high gate first appears in cycle DT+1 rather than in cycle DT. Enable and fault changes reach the gates one cycle after they are driven. The bench drives on the falling edge and samples on the falling edge. It locates cycle 0 of each period from the strobe and compares every cycle against the R4 formula. It applies duty changes before the strobe edge so that they land in the intended period.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int NUM_GATES = 2;
  localparam int GATE_HI   = 0;
  localparam int GATE_LO   = 1;

  function automatic int max_on_cycles(input int period, input int pct);
    return (period * pct) / 100;
  endfunction
endpackage

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int PERIOD  = 333,
  parameter int MAX_PCT = 90,
  parameter int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] duty_cmd,
  output logic [CW-1:0] ramp,
  output logic [CW-1:0] duty_q,
  output logic          wrap_stb
);
  import pwm_gate_pkg::*;

  localparam int            MAX_ON = max_on_cycles(PERIOD, MAX_PCT);
  localparam logic [CW-1:0] LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] CAP    = CW'(MAX_ON);

  logic          at_last;
  logic [CW-1:0] duty_lim;

  assign at_last  = (ramp == LAST);
  assign duty_lim = (duty_cmd > CAP) ? CAP : duty_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp     <= '0;
      duty_q   <= '0;
      wrap_stb <= 1'b0;
    end else begin
      wrap_stb <= at_last;
      if (at_last) begin
        ramp   <= '0;
        duty_q <= duty_lim;
      end else begin
        ramp <= ramp + 1'b1;
      end
    end
  end

  // R2: held duty never exceeds the cap
  p_duty_capped_r2: assert property (@(posedge clk) disable iff (rst)
    duty_q <= CAP);

  // R6: held duty changes only at a period boundary
  p_duty_held_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap_stb |-> $stable(duty_q));

  // R7: strobe lasts one cycle and coincides with ramp zero
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_stb |=> !wrap_stb);

  p_strobe_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_stb |-> (ramp == '0));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DT = 2,
  parameter int DW = $clog2(DT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic gate
);
  localparam logic [DW-1:0] DT_V = DW'(DT);

  logic [DW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      gate <= 1'b0;
    end else begin
      gate <= req && (run == DT_V);
      if (!req)
        run <= '0;
      else if (run != DT_V)
        run <= run + 1'b1;
    end
  end

  // R8: a withdrawn request turns the gate off on the next cycle
  p_off_follows_r8: assert property (@(posedge clk) disable iff (rst)
    !req |=> !gate);

  // R3: a gate only rises after its request was already present
  p_rise_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> $past(req));
endmodule

// File: rtl/sync_buck_pwm.sv
module sync_buck_pwm #(
  parameter int PERIOD  = 333,
  parameter int DT      = 2,
  parameter int MAX_PCT = 90,
  parameter int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] duty_cmd,
  input  logic          fault_off,
  output logic          hi_gate,
  output logic          lo_gate,
  output logic          period_start
);
  import pwm_gate_pkg::*;

  logic [CW-1:0]        ramp;
  logic [CW-1:0]        duty_q;
  logic                 active;
  logic                 below;
  logic [NUM_GATES-1:0] req;
  logic [NUM_GATES-1:0] gates;

  pwm_ramp #(.PERIOD(PERIOD), .MAX_PCT(MAX_PCT), .CW(CW)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .duty_cmd (duty_cmd),
    .ramp     (ramp),
    .duty_q   (duty_q),
    .wrap_stb (period_start)
  );

  assign active       = en && !fault_off;
  assign below        = (ramp < duty_q);
  assign req[GATE_HI] = active && below;
  assign req[GATE_LO] = active && !below;

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_chan
    pwm_deadband #(.DT(DT)) u_db (
      .clk  (clk),
      .rst  (rst),
      .req  (req[g]),
      .gate (gates[g])
    );
  end

  assign hi_gate = gates[GATE_HI];
  assign lo_gate = gates[GATE_LO];

  // R3: no shoot-through
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(hi_gate && lo_gate));

  // R3: each rising gate follows a cycle with the other gate off
  p_gap_before_hi_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_gate) |-> !$past(lo_gate));

  p_gap_before_lo_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_gate) |-> !$past(hi_gate));

  // R8: disable or fault forces both gates off next cycle
  p_forced_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!en || fault_off) |=> (!hi_gate && !lo_gate));
endmodule

// File: tb/sync_buck_pwm_test.sv
module sync_buck_pwm_test;
  localparam int PERIOD = 333;
  localparam int DT     = 2;
  localparam int CW     = $clog2(PERIOD);
  localparam int MAX_ON = (PERIOD * 90) / 100;
  localparam int NV     = 9;
  localparam int LIMIT  = 100000;

  // columns: command, expected high-gate cycles, expected low-gate cycles
  localparam int VEC [NV][3] = '{
    '{0,   0,   333},
    '{1,   0,   330},
    '{2,   0,   329},
    '{3,   1,   328},
    '{100, 98,  231},
    '{299, 297, 32},
    '{300, 297, 32},
    '{511, 297, 32},
    '{200, 198, 131}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          fault_off = 1'b0;
  logic [CW-1:0] duty_cmd = '0;
  logic          hi_gate, lo_gate, period_start;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  sync_buck_pwm #(.PERIOD(PERIOD), .DT(DT)) uut (
    .clk (clk), .rst (rst), .en (en), .duty_cmd (duty_cmd),
    .fault_off (fault_off), .hi_gate (hi_gate), .lo_gate (lo_gate),
    .period_start (period_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hi(input int c, input int d);
    return (c >= DT + 1) && (c <= d);
  endfunction

  function automatic bit exp_lo(input int c, input int d);
    if (d == 0) return 1'b1;
    return (c == 0) || (c >= d + DT + 1);
  endfunction

  task automatic wait_strobe();
    while (!period_start) @(negedge clk);
  endtask

  // starts at the strobe cycle, ends at the next period's cycle 0
  task automatic run_period(input int d, input int chg_at, input int chg_val,
                            output int hi_n, output int lo_n, output int bad,
                            output int ovl, output int sbad);
    hi_n = 0; lo_n = 0; bad = 0; ovl = 0; sbad = 0;
    for (int c = 0; c < PERIOD; c++) begin
      if (hi_gate) hi_n++;
      if (lo_gate) lo_n++;
      if (hi_gate !== exp_hi(c, d) || lo_gate !== exp_lo(c, d)) bad++;
      if (hi_gate && lo_gate) ovl++;
      if (period_start !== (c == 0)) sbad++;
      if (c == chg_at) duty_cmd = CW'(chg_val);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > LIMIT && !done) begin
        check(1'b0, "watchdog", n, LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    int hi_n, lo_n, bad, ovl, sbad, d, gap;
    string tag;
    duty_cmd = CW'(200);
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!hi_gate && !lo_gate && !period_start, "R1", {hi_gate, lo_gate, period_start}, 0);
    rst = 1'b0;
    duty_cmd = '0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      duty_cmd = CW'(VEC[i][0]);
      @(negedge clk);
      wait_strobe();
      d = (VEC[i][0] > MAX_ON) ? MAX_ON : VEC[i][0];
      run_period(d, -1, 0, hi_n, lo_n, bad, ovl, sbad);
      tag = (VEC[i][0] == 0) ? "R5" : ((VEC[i][0] > MAX_ON) ? "R2" : "R4");
      check(hi_n == VEC[i][1], tag, hi_n, VEC[i][1]);
      check(lo_n == VEC[i][2], tag, lo_n, VEC[i][2]);
      check(bad == 0, "R4", bad, 0);
      check(ovl == 0, "R3", ovl, 0);
      check(sbad == 0, "R7", sbad, 0);
    end

    // R6: mid-period change has no effect until the next period
    duty_cmd = CW'(100);
    @(negedge clk);
    wait_strobe();
    run_period(100, 50, 250, hi_n, lo_n, bad, ovl, sbad);
    check(hi_n == 98 && bad == 0, "R6", hi_n, 98);
    run_period(250, -1, 0, hi_n, lo_n, bad, ovl, sbad);
    check(hi_n == 248 && bad == 0, "R6", hi_n, 248);

    // R8: disable while the high gate is on
    duty_cmd = CW'(100);
    @(negedge clk);
    wait_strobe();
    repeat (50) @(negedge clk);
    check(hi_gate == 1'b1, "R4", hi_gate, 1);
    en = 1'b0;
    @(negedge clk);
    check(!hi_gate && !lo_gate, "R8", {hi_gate, lo_gate}, 0);
    wait_strobe();
    @(negedge clk);
    gap = 1; hi_n = 0;
    while (!period_start) begin
      if (hi_gate || lo_gate) hi_n++;
      gap++;
      @(negedge clk);
    end
    check(hi_n == 0, "R8", hi_n, 0);
    check(gap == PERIOD, "R7", gap, PERIOD);

    // R9: re-enable in the low-side part of the period
    repeat (150) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check(!lo_gate && !hi_gate, "R9", lo_gate, 0);
    @(negedge clk);
    check(!lo_gate, "R9", lo_gate, 0);
    @(negedge clk);
    check(lo_gate && !hi_gate, "R9", lo_gate, 1);

    // R8: fault-off while the low gate is on
    @(negedge clk);
    fault_off = 1'b1;
    @(negedge clk);
    check(!hi_gate && !lo_gate, "R8", {hi_gate, lo_gate}, 0);
    wait_strobe();
    run_period(0, -1, 0, hi_n, lo_n, bad, ovl, sbad);
    check(hi_n == 0 && lo_n == 0, "R8", hi_n + lo_n, 0);
    check(sbad == 0, "R7", sbad, 0);
    fault_off = 1'b0;

    // R1: reset during operation
    wait_strobe();
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!hi_gate && !lo_gate && !period_start, "R1", {hi_gate, lo_gate, period_start}, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule